// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block guards a five-stage in-order pipeline against the one data dependence that forwarding cannot cover. That dependence occurs when an instruction in decode needs a register that a load, now in execute, has not yet fetched from memory. The block compares the two source register fields of the decoding instruction with the destination field of the execute-stage instruction. The comparison only counts when the execute-stage instruction reads memory. When it finds a match, the block freezes the program counter and the fetch/decode register for one cycle. In that same cycle it writes an all-zero control bundle into the decode/execute register, so a harmless no-op flows down the pipe behind the load.

To make the block testable on its own, it owns three registers: the program counter, the fetch/decode register and the decode/execute control register. The decoder is outside the block and supplies the control bundle for the instruction held in fetch/decode. Instruction memory sits outside too and returns the word at the current program counter. The instruction word is 32 bits wide. Register fields are 5 bits wide: the first source field is at bits 25:21 and the second at bits 20:16.

Top module: `lu_stall_ctrl`

## Requirements
- R1: A stall is raised in a cycle exactly when bit 3 (memory-read) of the decode/execute control bundle is 1 and its stored destination field equals the decode instruction's bits 25:21 or bits 20:16.
- R2: During a stall cycle the program counter and the fetch/decode instruction and PC registers keep their values at the next edge.
- R3: During a stall cycle every bit of the control bundle loaded into decode/execute is zero at the next edge.
- R4: Outside a stall, each edge advances the program counter by 4. Fetch/decode loads the instruction word and the PC+4 value. Decode/execute loads the decoder's bundle and the decode instruction's bits 20:16.
- R5: A single load-use pair costs exactly one stall cycle: the cycle after a stall never stalls.
- R6: An execute-stage instruction whose memory-read bit is 0 never causes a stall, even when its destination field matches a decode source field.
- R7: Reset (active-low, asynchronous) sets the program counter to 0 and loads the no-op word (all zeros) into fetch/decode. It also clears the decode/execute control bundle and destination field.
- R8: The PC write enable and the fetch/decode write enable are the inverse of the stall, and the bubble select equals the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_rdata_i | input | 32 | Instruction word at the current program counter |
| id_ctrl_i | input | 8 | Decoder control bundle for the fetch/decode instruction: {alu_op[1:0], alu_src, reg_dst, mem_read, mem_write, reg_write, mem_to_reg} |
| pc_o | output | 32 | Program counter |
| ifid_instr_o | output | 32 | Instruction held in fetch/decode |
| ifid_pc_o | output | 32 | PC+4 value held in fetch/decode |
| idex_ctrl_o | output | 8 | Control bundle held in decode/execute |
| idex_rd_o | output | 5 | Destination field held in decode/execute |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode write enable |
| bubble_sel_o | output | 1 | Selects the zero bundle into decode/execute |

## Verification
Several properties are checked on every cycle: the register hold and step rules around the write enables, the zero bundle after a bubble select, the absence of a second stall directly after one, and the rule that a non-load never stalls. Only the bench's scenarios can show that the match condition fires for the right field pairs and stays quiet for independent instructions. They also show that the whole cycle-by-cycle timeline comes out right after reset: PC values, held instruction and bundle contents. The cases covered are a load followed by a dependent operation through either source field, a load followed by an independent operation, back-to-back loads, and an arithmetic producer with a matching field.

// File: rtl/lu_pkg.sv
package lu_pkg;
  typedef struct packed {
    logic [1:0] alu_op;
    logic       alu_src;
    logic       reg_dst;
    logic       mem_read;
    logic       mem_write;
    logic       reg_write;
    logic       mem_to_reg;
  } ctrl_t;

  localparam int unsigned CTRL_W   = $bits(ctrl_t);
  localparam int unsigned NUM_SRC  = 2;
  localparam int unsigned RS_LSB   = 21;
  localparam int unsigned RT_LSB   = 16;
endpackage

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RA_W = 5
) (
  input  logic [XLEN-1:0] ifid_instr_i,
  input  logic            idex_mem_read_i,
  input  logic [RA_W-1:0] idex_rd_i,
  output logic            stall_o
);
  import lu_pkg::*;

  localparam int unsigned SRC_LSB [NUM_SRC] = '{RS_LSB, RT_LSB};

  logic [NUM_SRC-1:0] src_hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_hit[g] = (ifid_instr_i[SRC_LSB[g] +: RA_W] == idex_rd_i);
  end

  assign stall_o = idex_mem_read_i && (|src_hit);
endmodule

// File: rtl/lu_fetch_regs.sv
module lu_fetch_regs #(
  parameter int unsigned XLEN      = 32,
  parameter logic [31:0] NOP_INSTR = '0,
  parameter int unsigned PC_STEP   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pc_we_i,
  input  logic            ifid_we_i,
  input  logic [XLEN-1:0] imem_rdata_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] ifid_instr_o,
  output logic [XLEN-1:0] ifid_pc_o
);
  logic [XLEN-1:0] pc_q, pc_inc, instr_q, ipc_q;

  assign pc_inc = pc_q + XLEN'(PC_STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (pc_we_i) begin
      pc_q <= pc_inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_q <= XLEN'(NOP_INSTR);
      ipc_q   <= '0;
    end else if (ifid_we_i) begin
      instr_q <= imem_rdata_i;
      ipc_q   <= pc_inc;
    end
  end

  assign pc_o         = pc_q;
  assign ifid_instr_o = instr_q;
  assign ifid_pc_o    = ipc_q;

  p_pc_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_we_i |=> pc_q == $past(pc_q));
  p_ifid_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ifid_we_i |=> (instr_q == $past(instr_q)) && (ipc_q == $past(ipc_q)));
  p_pc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_i |=> pc_q == $past(pc_q) + XLEN'(PC_STEP));
endmodule

// File: rtl/lu_idex_ctrl.sv
module lu_idex_ctrl #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RA_W = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bubble_sel_i,
  input  logic [lu_pkg::CTRL_W-1:0] id_ctrl_i,
  input  logic [XLEN-1:0]           ifid_instr_i,
  output lu_pkg::ctrl_t             ctrl_o,
  output logic [RA_W-1:0]           rd_o
);
  import lu_pkg::*;

  ctrl_t ctrl_d, ctrl_q;
  logic [RA_W-1:0] rd_q;

  // zero bundle mux ahead of the register
  always_comb begin
    ctrl_d = ctrl_t'(id_ctrl_i);
    if (bubble_sel_i) ctrl_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      rd_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      rd_q   <= ifid_instr_i[RT_LSB +: RA_W];
    end
  end

  assign ctrl_o = ctrl_q;
  assign rd_o   = rd_q;

  p_bubble_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_sel_i |=> ctrl_q == '0);
  p_ctrl_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bubble_sel_i |=> ctrl_q == $past(ctrl_t'(id_ctrl_i)));
endmodule

// File: rtl/lu_stall_ctrl.sv
module lu_stall_ctrl #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned RA_W      = 5,
  parameter logic [31:0] NOP_INSTR = '0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [XLEN-1:0]           imem_rdata_i,
  input  logic [lu_pkg::CTRL_W-1:0] id_ctrl_i,
  output logic [XLEN-1:0]           pc_o,
  output logic [XLEN-1:0]           ifid_instr_o,
  output logic [XLEN-1:0]           ifid_pc_o,
  output logic [lu_pkg::CTRL_W-1:0] idex_ctrl_o,
  output logic [RA_W-1:0]           idex_rd_o,
  output logic                      pc_we_o,
  output logic                      ifid_we_o,
  output logic                      bubble_sel_o
);
  import lu_pkg::*;

  logic            stall;
  logic [XLEN-1:0] ifid_instr;
  ctrl_t           idex_ctrl;
  logic [RA_W-1:0] idex_rd;

  lu_hazard_detect #(.XLEN(XLEN), .RA_W(RA_W)) u_hazard (
    .ifid_instr_i    (ifid_instr),
    .idex_mem_read_i (idex_ctrl.mem_read),
    .idex_rd_i       (idex_rd),
    .stall_o         (stall)
  );

  lu_fetch_regs #(.XLEN(XLEN), .NOP_INSTR(NOP_INSTR)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pc_we_i      (pc_we_o),
    .ifid_we_i    (ifid_we_o),
    .imem_rdata_i (imem_rdata_i),
    .pc_o         (pc_o),
    .ifid_instr_o (ifid_instr),
    .ifid_pc_o    (ifid_pc_o)
  );

  lu_idex_ctrl #(.XLEN(XLEN), .RA_W(RA_W)) u_idex (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bubble_sel_i (bubble_sel_o),
    .id_ctrl_i    (id_ctrl_i),
    .ifid_instr_i (ifid_instr),
    .ctrl_o       (idex_ctrl),
    .rd_o         (idex_rd)
  );

  assign pc_we_o      = !stall;
  assign ifid_we_o    = !stall;
  assign bubble_sel_o = stall;
  assign ifid_instr_o = ifid_instr;
  assign idex_ctrl_o  = idex_ctrl;
  assign idex_rd_o    = idex_rd;

  p_single_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> !stall);
  p_noload_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idex_ctrl.mem_read |-> !stall);
  p_enables_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_o == ifid_we_o) && (bubble_sel_o != pc_we_o));
endmodule

// File: tb/lu_stall_ctrl_tb.sv
module lu_stall_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_rdata;
  logic [7:0]  id_ctrl;
  logic [31:0] pc, ifid_instr, ifid_pc;
  logic [7:0]  idex_ctrl;
  logic [4:0]  idex_rd;
  logic        pc_we, ifid_we, bubble_sel;
  logic [31:0] prog [16];
  int          errors = 0;
  int          checks = 0;

  localparam logic [7:0] C_LOAD = 8'h2B;
  localparam logic [7:0] C_ALU  = 8'h92;

  always #10 clk = ~clk;

  lu_stall_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .imem_rdata_i(imem_rdata), .id_ctrl_i(id_ctrl),
    .pc_o(pc), .ifid_instr_o(ifid_instr), .ifid_pc_o(ifid_pc),
    .idex_ctrl_o(idex_ctrl), .idex_rd_o(idex_rd),
    .pc_we_o(pc_we), .ifid_we_o(ifid_we), .bubble_sel_o(bubble_sel)
  );

  function automatic logic [31:0] ld(input int rt, input int rs);
    return {6'h23, 5'(rs), 5'(rt), 16'h0004};
  endfunction
  function automatic logic [31:0] alu(input int rd, input int rs, input int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
  endfunction
  function automatic logic [7:0] dec(input logic [31:0] w);
    if (w == 32'd0) return 8'h00;
    if (w[31:26] == 6'h23) return C_LOAD;
    return C_ALU;
  endfunction

  // environment: instruction memory and decoder
  assign imem_rdata = prog[pc[5:2]];
  assign id_ctrl    = dec(ifid_instr);

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic start(input logic [31:0] i0, input logic [31:0] i1, input logic [31:0] i2);
    for (int k = 0; k < 16; k++) prog[k] = 32'd0;
    prog[0] = i0; prog[1] = i1; prog[2] = i2;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  // runs i0 (producer), i1 (consumer), i2 and checks the timeline
  task automatic run_pair(input string req, input logic [31:0] i0, input logic [31:0] i1,
                          input logic [31:0] i2, input logic exp_stall);
    start(i0, i1, i2);
    @(negedge clk);
    chk(req, "pc after 1", pc, 32'd4);
    @(negedge clk);
    chk(req, "idex ctrl", {24'd0, idex_ctrl}, {24'd0, dec(i0)});
    chk("R4", "idex rd", {27'd0, idex_rd}, {27'd0, i0[20:16]});
    chk(req, "stall", {31'd0, bubble_sel}, {31'd0, exp_stall});
    chk("R8", "pc_we", {31'd0, pc_we}, {31'd0, !exp_stall});
    chk("R8", "ifid_we", {31'd0, ifid_we}, {31'd0, !exp_stall});
    @(negedge clk);
    if (exp_stall) begin
      chk("R2", "pc held", pc, 32'd8);
      chk("R2", "ifid held", ifid_instr, i1);
      chk("R2", "ifid pc held", ifid_pc, 32'd8);
      chk("R3", "bubble ctrl", {24'd0, idex_ctrl}, 32'd0);
      chk("R5", "no 2nd stall", {31'd0, bubble_sel}, 32'd0);
      @(negedge clk);
    end
    chk("R4", "pc step", pc, 32'd12);
    chk("R4", "ifid instr", ifid_instr, i2);
    chk("R4", "ifid pc", ifid_pc, 32'd12);
    chk("R4", "consumer ctrl", {24'd0, idex_ctrl}, {24'd0, dec(i1)});
  endtask

  task automatic t_reset();
    start(ld(1, 2), alu(4, 1, 5), 32'd0);
    rst_n = 1'b0;
    #1;
    chk("R7", "pc", pc, 32'd0);
    chk("R7", "ifid", ifid_instr, 32'd0);
    chk("R7", "idex ctrl", {24'd0, idex_ctrl}, 32'd0);
    chk("R7", "idex rd", {27'd0, idex_rd}, 32'd0);
    chk("R8", "pc_we in reset", {31'd0, pc_we}, 32'd1);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_dep_rs();  run_pair("R1", ld(1, 2), alu(4, 1, 5), alu(8, 9, 10), 1'b1); endtask
  task automatic t_dep_rt();  run_pair("R1", ld(7, 2), alu(4, 5, 7), alu(8, 9, 10), 1'b1); endtask
  task automatic t_indep();   run_pair("R1", ld(1, 2), alu(4, 3, 5), alu(8, 9, 10), 1'b0); endtask
  task automatic t_ld_ld();   run_pair("R1", ld(3, 2), ld(6, 3), alu(8, 6, 10), 1'b1); endtask
  task automatic t_ld_ld_rt(); run_pair("R1", ld(3, 2), ld(3, 9), alu(8, 9, 10), 1'b1); endtask
  task automatic t_alu_prod(); run_pair("R6", alu(9, 1, 2), alu(4, 2, 3), alu(8, 9, 10), 1'b0); endtask

  // chained loads: second load's result used by third instruction
  task automatic t_chain();
    start(ld(1, 2), ld(5, 6), alu(4, 5, 7));
    prog[3] = alu(8, 9, 10);
    repeat (3) @(negedge clk);
    chk("R1", "chain stall", {31'd0, bubble_sel}, 32'd1);
    chk("R2", "chain pc", pc, 32'd12);
    @(negedge clk);
    chk("R5", "chain single", {31'd0, bubble_sel}, 32'd0);
    chk("R2", "chain pc hold", pc, 32'd12);
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) prog[k] = 32'd0;
    t_reset();
    t_dep_rs();
    t_dep_rt();
    t_indep();
    t_ld_ld();
    t_ld_ld_rt();
    t_alu_prod();
    t_chain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule